// File: doc/BRIEF.md
# Conditional Jump Program Counter

This block keeps the program counter of a small 16-bit processor and settles, once per clock, whether the next fetch address comes from a branch or from the next sequential slot. It looks at the instruction word being executed, the zero and negative status flags produced by the ALU for that instruction, and the value held in the address register. If the instruction is a compute-type instruction and one of the conditions it selects holds, the counter is loaded from the address register. Otherwise the counter advances by one.

Each cycle the update is classified into one of three named actions: CLEAR (synchronous reset), LOAD (branch taken) and STEP (sequential advance). They are chosen in that priority order. The transitions are CLEAR on reset, LOAD when the condition is met and reset is low, and STEP in every other cycle. The chosen action is applied at the next rising clock edge. A jump strobe shows, in the same cycle, that the LOAD action has been picked.

Top module: `jump_pc`

## Requirements
- R1: While `rst` is 1 at a rising edge, `pc` becomes 16'h0000 after that edge, even when the branch condition also holds, and `jump` is 0 in that cycle.
- R2: With `rst` 0 and no branch taken, `pc` after the edge equals the previous `pc` plus one.
- R3: With `rst` 0 and a branch taken, `pc` after the edge equals the value `areg` held before that edge.
- R4: When `instr[15]` is 0, no branch is taken, whatever the jump field and the flags are.
- R5: Jump field `instr[2:0]` = 3'b001 branches only when `zr` = 0 and `ng` = 0. A result of -1 (`ng` = 1) does not branch.
- R6: Jump field bit `instr[2]` set makes the branch taken whenever `ng` = 1.
- R7: Jump field bit `instr[1]` set makes the branch taken whenever `zr` = 1.
- R8: With `instr[15]` = 1, field 3'b000 never branches and field 3'b111 always branches.
- R9: Instruction bits [14:3], including the destination bits, have no effect on the branch decision.
- R10: Incrementing from 16'hFFFF gives 16'h0000.
- R11: `jump` is 1 in exactly the cycles in which `pc` will load from `areg` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Current instruction word. Bit 15 marks compute type, bits [2:0] are the jump field |
| zr | input | 1 | ALU result is zero |
| ng | input | 1 | ALU result is negative |
| areg | input | 16 | Address register value, used as the branch target |
| pc | output | 16 | Current program counter |
| jump | output | 1 | High when the counter will load from `areg` at the next edge |

## Verification
The bench drives an ALU result as a signed integer and derives the flags from it. Its reference therefore judges "greater than zero" by the number itself, not from flag bits. A design that took `zr` = 0 alone as positive would branch on -1 under field 001. A design that tested the destination bits or ignored bit 15 would branch on non-compute words or on varied upper bits. The bench also applies reset together with an always-branch instruction, which exposes a load placed above reset in priority. It increments through 16'hFFFF to check the wrap, so a counter that saturates there would fail.

// File: rtl/jpc_pkg.sv
package jpc_pkg;
    typedef enum logic [1:0] {
        PC_CLEAR = 2'd0,
        PC_LOAD  = 2'd1,
        PC_STEP  = 2'd2
    } pc_act_e;
endpackage

// File: rtl/jpc_cond.sv
// Branch condition: one lane per jump-field bit, each paired with its flag test.
module jpc_cond #(
    parameter int INSTR_W   = 16,
    parameter int CTYPE_BIT = 15,
    parameter int JF_LSB    = 0
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               zr,
    input  logic               ng,
    output logic               take
);
    localparam int JF_W = 3;

    logic [JF_W-1:0] flag_ok;
    logic [JF_W-1:0] lane_hit;

    // lane 0: strictly positive, lane 1: zero, lane 2: negative
    assign flag_ok = {ng, zr, ~(zr | ng)};

    for (genvar g = 0; g < JF_W; g++) begin : g_lane
        assign lane_hit[g] = instr[JF_LSB + g] & flag_ok[g];
    end

    assign take = instr[CTYPE_BIT] & (|lane_hit);
endmodule

// File: rtl/jpc_ctrl.sv
// Chooses the update action for this cycle: CLEAR > LOAD > STEP.
module jpc_ctrl
    import jpc_pkg::*;
(
    input  logic    rst,
    input  logic    take,
    output pc_act_e act,
    output logic    jump
);
    always_comb begin
        if (rst) begin
            act = PC_CLEAR;
        end else if (take) begin
            act = PC_LOAD;
        end else begin
            act = PC_STEP;
        end
    end

    always_comb begin
        unique case (act)
            PC_LOAD:  jump = 1'b1;
            PC_CLEAR: jump = 1'b0;
            PC_STEP:  jump = 1'b0;
            default:  jump = 1'b0;
        endcase
    end
endmodule

// File: rtl/jpc_reg.sv
// Program counter register, updated according to the chosen action.
module jpc_reg
    import jpc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  pc_act_e         act,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] PC_ONE  = PC_W'(1);
    localparam logic [PC_W-1:0] PC_ZERO = '0;

    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        unique case (act)
            PC_CLEAR: pc_q <= PC_ZERO;
            PC_LOAD:  pc_q <= target;
            PC_STEP:  pc_q <= pc_q + PC_ONE;
            default:  pc_q <= PC_ZERO;
        endcase
    end

    assign pc = pc_q;
endmodule

// File: rtl/jump_pc.sv
module jump_pc
    import jpc_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int INSTR_W   = 16,
    parameter int CTYPE_BIT = INSTR_W - 1,
    parameter int JF_LSB    = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               zr,
    input  logic               ng,
    input  logic [PC_W-1:0]    areg,
    output logic [PC_W-1:0]    pc,
    output logic               jump
);
    logic    take;
    pc_act_e act;

    jpc_cond #(
        .INSTR_W  (INSTR_W),
        .CTYPE_BIT(CTYPE_BIT),
        .JF_LSB   (JF_LSB)
    ) u_cond (
        .instr(instr),
        .zr   (zr),
        .ng   (ng),
        .take (take)
    );

    jpc_ctrl u_ctrl (
        .rst (rst),
        .take(take),
        .act (act),
        .jump(jump)
    );

    jpc_reg #(
        .PC_W(PC_W)
    ) u_reg (
        .clk   (clk),
        .act   (act),
        .target(areg),
        .pc    (pc)
    );
endmodule

// File: rtl/jump_pc_chk.sv
module jump_pc_chk #(
    parameter int PC_W    = 16,
    parameter int INSTR_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [INSTR_W-1:0] instr,
    input logic               zr,
    input logic               ng,
    input logic [PC_W-1:0]    areg,
    input logic [PC_W-1:0]    pc,
    input logic               jump
);
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> pc == '0);
    a_r1_no_jump_in_reset: assert property (@(posedge clk) rst |-> !jump);
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        !jump |=> pc == $past(pc) + PC_W'(1));
    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        jump |=> pc == $past(areg));
    a_r4_non_compute: assert property (@(posedge clk) disable iff (rst)
        !instr[INSTR_W-1] |-> !jump);
    a_r5_not_positive: assert property (@(posedge clk) disable iff (rst)
        (instr[2:0] == 3'b001 && (zr || ng)) |-> !jump);
    a_r6_negative: assert property (@(posedge clk) disable iff (rst)
        (instr[INSTR_W-1] && instr[2] && ng) |-> jump);
    a_r7_zero: assert property (@(posedge clk) disable iff (rst)
        (instr[INSTR_W-1] && instr[1] && zr) |-> jump);
    a_r8_never: assert property (@(posedge clk) disable iff (rst)
        (instr[2:0] == 3'b000) |-> !jump);
    a_r8_always: assert property (@(posedge clk) disable iff (rst)
        (instr[INSTR_W-1] && instr[2:0] == 3'b111) |-> jump);
    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        (!jump && pc == '1) |=> pc == '0);
endmodule

bind jump_pc jump_pc_chk #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .instr(instr),
    .zr   (zr),
    .ng   (ng),
    .areg (areg),
    .pc   (pc),
    .jump (jump)
);

// File: tb/tb_jump_pc.sv
module tb_jump_pc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = '0;
    logic        zr = 1'b0;
    logic        ng = 1'b0;
    logic [15:0] areg = '0;
    logic [15:0] pc;
    logic        jump;

    int n_checks = 0;
    int n_fail = 0;
    int exp_pc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    jump_pc dut (
        .clk  (clk),
        .rst  (rst),
        .instr(instr),
        .zr   (zr),
        .ng   (ng),
        .areg (areg),
        .pc   (pc),
        .jump (jump)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: drive inputs after a falling edge, check the strobe,
    // then check pc just after the rising edge against the reference.
    task automatic cycle(input logic [15:0] w, input int alu, input logic [15:0] a,
                         input logic r, input string req);
        bit gt, eq, lt, take;
        @(negedge clk);
        instr = w;
        zr = (alu == 0);
        ng = (alu < 0);
        areg = a;
        rst = r;
        gt = alu > 0;
        eq = alu == 0;
        lt = alu < 0;
        take = !r && w[15] && ((w[0] && gt) || (w[1] && eq) || (w[2] && lt));
        #1;
        check({req, "/R11 strobe"}, int'(jump), int'(take));
        @(posedge clk);
        #1;
        if (r) exp_pc = 0;
        else if (take) exp_pc = int'(a);
        else exp_pc = (exp_pc + 1) % 65536;
        check({req, " pc"}, int'(pc), exp_pc);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        // R1: reset state
        cycle(16'h0000, 5, 16'h1234, 1'b1, "R1");
        cycle(16'h0000, 5, 16'h1234, 1'b1, "R1");
        // R2: plain steps
        cycle(16'h0007, 5, 16'h1234, 1'b0, "R2");
        cycle(16'h0000, -3, 16'h1234, 1'b0, "R2");
        // R3 + R5: positive under 001 branches
        cycle(16'h8001, 7, 16'h0200, 1'b0, "R3/R5");
        // R5: -1 under 001 does not branch, zero does not either
        cycle(16'h8001, -1, 16'h03E8, 1'b0, "R5");
        cycle(16'h8001, 0, 16'h03E8, 1'b0, "R5");
        // R6: negative bit
        cycle(16'h8004, -9, 16'h0044, 1'b0, "R6");
        cycle(16'h8004, 9, 16'h0055, 1'b0, "R6");
        // R7: zero bit
        cycle(16'h8002, 0, 16'h0066, 1'b0, "R7");
        cycle(16'h8002, -2, 16'h0077, 1'b0, "R7");
        // R8: never / always
        cycle(16'h8000, 0, 16'h0088, 1'b0, "R8");
        cycle(16'h8007, 3, 16'h0099, 1'b0, "R8");
        cycle(16'h8007, -3, 16'h00AA, 1'b0, "R8");
        // R4: non-compute words never branch
        cycle(16'h0007, 0, 16'h0BBB, 1'b0, "R4");
        cycle(16'h7FFF, -4, 16'h0CCC, 1'b0, "R4");
        // R9: upper/destination bits do not matter
        cycle(16'hFFF8, 5, 16'h0DDD, 1'b0, "R9");
        cycle(16'hC039, 5, 16'h0EEE, 1'b0, "R9");
        cycle(16'hBFCA, 6, 16'h0FFF, 1'b0, "R9");
        // R1: reset wins over an always-branch
        cycle(16'h8007, 0, 16'h4321, 1'b1, "R1");
        // R10: wrap through FFFF
        cycle(16'h8007, 1, 16'hFFFF, 1'b0, "R10");
        cycle(16'h0000, 1, 16'h1111, 1'b0, "R10");
        cycle(16'h0000, 1, 16'h1111, 1'b0, "R10");
        // Mixed patterns against the reference (R2 R3 R11)
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cycle({lf[15], lf[9:3], lf[14:10], lf[2:0]}, int'(lf[7:6]) - 2,
                  {lf[7:0], lf[15:8]}, (lf[11:4] == 8'h00), "R2/R3 mixed");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule